// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a 40-bit physical address. It walks four levels of page tables held in memory. The first table's base comes from a root input that is sampled when a request is accepted. Each step reads one 64-bit entry through a simple memory port: a one-cycle request pulse with an address, then a valid pulse with data in some later cycle. Every entry is checked as it arrives. The walk stops at the first entry that denies the access.

The requester supplies the address and three attributes: write access, user-mode access and instruction fetch. It also supplies a switch that turns no-execute enforcement on or off. The walker takes one request at a time and stays busy until it pulses `done`. On that pulse it reports either the translated address or a fault code, together with the walk step at which the fault arose.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are all 0.
- R2: If any of bits [63:48] of the virtual address differs from bit 47, the request ends with fault code 1 and level 0. No memory read is issued.
- R3: Step 0 reads the entry at `root_base` + 8 × VA[47:39]. Steps 1, 2 and 3 read at base + 8 × VA[38:30], VA[29:21] and VA[20:12]. That base is the previous entry's bits [39:12] followed by 12 zero bits.
- R4: A walk with no fault ends with fault code 0, level 3 and `done_paddr` = {step-3 entry bits [39:12], VA[11:0]}.
- R5: An entry whose bit 0 (present) is 0 ends the walk with fault code 2, and `done_level` gives the step that read it. No further reads follow.
- R6: A write access through an entry whose bit 1 (writable) is 0 faults with code 3. A read through the same entries translates normally.
- R7: A user access through an entry whose bit 2 (user) is 0 faults with code 4. A supervisor access through the same entries translates normally.
- R8: An instruction fetch through an entry whose bit 63 is 1 faults with code 5, but only while `nx_en` is 1. With `nx_en` at 0, or for a non-fetch access, bit 63 has no effect.
- R9: When one entry breaks several rules, the reported code follows this priority: not-present (2) first, then write (3), then user (4), then no-execute (5).
- R10: `busy` is 1 from the cycle after acceptance until `done`. `done` lasts one cycle. A `req_valid` seen while busy is ignored and produces no later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New translation request, accepted when idle |
| req_vaddr | input | 64 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| req_fetch | input | 1 | Access is an instruction fetch |
| nx_en | input | 1 | Enables the no-execute check |
| root_base | input | 40 | Physical base of the top-level table |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | One-cycle read request for a table entry |
| mem_addr | output | 40 | Byte address of the requested entry |
| mem_rvalid | input | 1 | Read data is valid |
| mem_rdata | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle completion pulse |
| done_paddr | output | 40 | Translated physical address (valid when fault is 0) |
| done_fault | output | 3 | 0 none, 1 non-canonical, 2 not-present, 3 write, 4 user, 5 no-execute |
| done_level | output | 2 | Walk step (0 = top table, 3 = last table) of the result |

## Verification
The walk is tried with a low canonical address, a high sign-extended address and a non-canonical one. Comparing these separates correct sign-extension handling from a plain zero check, and the read count shows whether a bad address ever touches memory. A single permission bit is then cleared at a chosen step, and each case is driven with both the denying and the allowed access kind. This shows that a fault comes from the right bit at the right step and nowhere else. Entries with several bad bits at once pin down the fault priority. A second request sent during a walk shows that it is dropped and not queued.

// File: rtl/pw_pkg.sv
package pw_pkg;
    typedef enum logic [2:0] {
        F_NONE     = 3'd0,
        F_NONCANON = 3'd1,
        F_NOTPRES  = 3'd2,
        F_WRITE    = 3'd3,
        F_USER     = 3'd4,
        F_NX       = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_START = 2'd1,
        S_WAIT  = 2'd2
    } state_e;

    localparam int BIT_PRESENT = 0;
    localparam int BIT_WRITE   = 1;
    localparam int BIT_USER    = 2;
endpackage

// File: rtl/pw_vsplit.sv
// Picks the table index for one walk step and flags non-canonical addresses.
module pw_vsplit #(
    parameter int VA_W   = 64,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int LEVELS = 4,
    localparam int LVL_W   = $clog2(LEVELS),
    localparam int VA_USED = OFF_W + LEVELS * IDX_W
) (
    input  logic [VA_W-1:0]  va,
    input  logic [LVL_W-1:0] lvl,
    output logic [IDX_W-1:0] idx,
    output logic             canon
);
    logic [IDX_W-1:0] idx_arr [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx_arr[g] = va[OFF_W + (LEVELS - 1 - g) * IDX_W +: IDX_W];
    end

    assign idx = idx_arr[lvl];

    logic [VA_W-VA_USED:0] upper;
    assign upper = va[VA_W-1:VA_USED-1];
    assign canon = (&upper) | ~(|upper);
endmodule

// File: rtl/pw_perm.sv
// Evaluates one table entry against the access kind, in fixed priority order.
module pw_perm #(
    parameter int ENT_W = 64
) (
    input  logic [ENT_W-1:0] entry,
    input  logic             wr,
    input  logic             us,
    input  logic             fx,
    input  logic             nx_on,
    output pw_pkg::fault_e   fault
);
    import pw_pkg::*;

    always_comb begin
        if (!entry[BIT_PRESENT])             fault = F_NOTPRES;
        else if (wr && !entry[BIT_WRITE])    fault = F_WRITE;
        else if (us && !entry[BIT_USER])     fault = F_USER;
        else if (fx && nx_on && entry[ENT_W-1]) fault = F_NX;
        else                                 fault = F_NONE;
    end

    // R9: a missing entry always reports as not-present first
    always_comb begin
        assert (entry[BIT_PRESENT] || fault == F_NOTPRES);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
    parameter int VA_W   = 64,
    parameter int PA_W   = 40,
    parameter int ENT_W  = 64,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int LEVELS = 4,
    localparam int LVL_W  = $clog2(LEVELS),
    localparam int ENT_SH = $clog2(ENT_W / 8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    input  logic             req_fetch,
    input  logic             nx_en,
    input  logic [PA_W-1:0]  root_base,
    output logic             busy,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [ENT_W-1:0] mem_rdata,
    output logic             done,
    output logic [PA_W-1:0]  done_paddr,
    output logic [2:0]       done_fault,
    output logic [LVL_W-1:0] done_level
);
    import pw_pkg::*;

    typedef struct packed {
        state_e            st;
        logic [LVL_W-1:0]  lvl;
        logic [PA_W-1:0]   base;
        logic [VA_W-1:0]   va;
        logic              wr;
        logic              us;
        logic              fx;
        logic              nxo;
        logic              done;
        logic [PA_W-1:0]   paddr;
        fault_e            fault;
        logic [LVL_W-1:0]  flvl;
        logic              mreq;
        logic [PA_W-1:0]   maddr;
    } regs_t;

    regs_t r_d, r_q;

    logic [LVL_W-1:0] look_lvl_d;
    logic [IDX_W-1:0] idx_d;
    logic             canon_d;
    fault_e           ent_fault_d;
    logic [PA_W-1:0]  ent_off_d;
    logic [PA_W-1:0]  next_base_d;

    assign look_lvl_d = (r_q.st == S_WAIT) ? LVL_W'(r_q.lvl + 1'b1) : '0;

    pw_vsplit #(
        .VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS)
    ) u_vsplit (
        .va    (r_q.va),
        .lvl   (look_lvl_d),
        .idx   (idx_d),
        .canon (canon_d)
    );

    pw_perm #(.ENT_W(ENT_W)) u_perm (
        .entry (mem_rdata),
        .wr    (r_q.wr),
        .us    (r_q.us),
        .fx    (r_q.fx),
        .nx_on (r_q.nxo),
        .fault (ent_fault_d)
    );

    assign ent_off_d   = PA_W'({idx_d, {ENT_SH{1'b0}}});
    assign next_base_d = {mem_rdata[PA_W-1:OFF_W], {OFF_W{1'b0}}};

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.mreq = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.st   = S_START;
                    r_d.va   = req_vaddr;
                    r_d.wr   = req_write;
                    r_d.us   = req_user;
                    r_d.fx   = req_fetch;
                    r_d.nxo  = nx_en;
                    r_d.base = root_base;
                    r_d.lvl  = '0;
                end
            end
            S_START: begin
                if (!canon_d) begin
                    r_d.done  = 1'b1;
                    r_d.fault = F_NONCANON;
                    r_d.flvl  = '0;
                    r_d.paddr = '0;
                    r_d.st    = S_IDLE;
                end else begin
                    r_d.mreq  = 1'b1;
                    r_d.maddr = r_q.base + ent_off_d;
                    r_d.st    = S_WAIT;
                end
            end
            S_WAIT: begin
                if (mem_rvalid) begin
                    if (ent_fault_d != F_NONE) begin
                        r_d.done  = 1'b1;
                        r_d.fault = ent_fault_d;
                        r_d.flvl  = r_q.lvl;
                        r_d.paddr = '0;
                        r_d.st    = S_IDLE;
                    end else if (r_q.lvl == LVL_W'(LEVELS - 1)) begin
                        r_d.done  = 1'b1;
                        r_d.fault = F_NONE;
                        r_d.flvl  = r_q.lvl;
                        r_d.paddr = {mem_rdata[PA_W-1:OFF_W], r_q.va[OFF_W-1:0]};
                        r_d.st    = S_IDLE;
                    end else begin
                        r_d.lvl   = LVL_W'(r_q.lvl + 1'b1);
                        r_d.base  = next_base_d;
                        r_d.mreq  = 1'b1;
                        r_d.maddr = next_base_d + ent_off_d;
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy       = (r_q.st != S_IDLE);
    assign mem_req    = r_q.mreq;
    assign mem_addr   = r_q.maddr;
    assign done       = r_q.done;
    assign done_paddr = r_q.paddr;
    assign done_fault = r_q.fault;
    assign done_level = r_q.flvl;

    p_mem_in_walk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_noncanon_step0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault == F_NONCANON) |-> (done_level == '0 && !mem_req));

    p_success_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault == F_NONE) |-> done_level == LVL_W'(LEVELS - 1));

    p_fault_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> done_fault <= F_NX);
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_vaddr = '0;
    logic        req_write = 1'b0, req_user = 1'b0, req_fetch = 1'b0, nx_en = 1'b0;
    logic [39:0] root_base = '0;
    logic        busy, mem_req, mem_rvalid, done;
    logic [39:0] mem_addr, done_paddr;
    logic [63:0] mem_rdata;
    logic [2:0]  done_fault;
    logic [1:0]  done_level;

    always #5 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .req_fetch(req_fetch),
        .nx_en(nx_en), .root_base(root_base), .busy(busy), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .done_paddr(done_paddr), .done_fault(done_fault),
        .done_level(done_level)
    );

    localparam logic [39:0] ROOT  = 40'h00_0001_0000;
    localparam logic [39:0] TB1   = 40'h00_0002_0000;
    localparam logic [39:0] TB2   = 40'h00_0003_0000;
    localparam logic [39:0] TB3   = 40'h00_0004_0000;
    localparam logic [39:0] FRAME = 40'h0A_BCDE_F000;

    logic [63:0] mem [logic [39:0]];
    int          rd_total = 0;
    logic [39:0] rd_log [8];
    int n_cmp = 0, n_bad = 0;

    logic [39:0] r_paddr;
    logic [2:0]  r_fault;
    logic [1:0]  r_level;
    int          r_reads;
    int          r_start;

    // memory model: one cycle after a request, return the entry
    always @(posedge clk) begin
        if (mem_req) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
            rd_log[rd_total % 8] <= mem_addr;
            rd_total <= rd_total + 1;
        end else begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [39:0] base, input logic [3:0] fl);
        return {fl[3], 23'b0, base[39:12], 9'b0, fl[2:0]};
    endfunction

    function automatic logic [39:0] eaddr(input logic [39:0] base, input logic [8:0] ix);
        return base + {28'b0, ix, 3'b000};
    endfunction

    // fl bit3 = entry bit 63, bits 2:0 = user, writable, present
    task automatic build(input logic [63:0] va, input logic [3:0] f0, input logic [3:0] f1,
                         input logic [3:0] f2, input logic [3:0] f3);
        mem.delete();
        mem[eaddr(ROOT, va[47:39])] = mk(TB1, f0);
        mem[eaddr(TB1,  va[38:30])] = mk(TB2, f1);
        mem[eaddr(TB2,  va[29:21])] = mk(TB3, f2);
        mem[eaddr(TB3,  va[20:12])] = mk(FRAME, f3);
    endtask

    task automatic wait_done();
        bit got = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done) begin
                got = 1;
                r_paddr = done_paddr; r_fault = done_fault; r_level = done_level;
                break;
            end
        end
        if (!got) begin
            n_cmp++; n_bad++;
            $display("FAIL R10: actual no done expected done");
            r_fault = 3'h7;
        end
        @(negedge clk);
        r_reads = rd_total - r_start;
    endtask

    task automatic run(input logic [63:0] va, input logic w, input logic u,
                       input logic f, input logic nx);
        @(negedge clk);
        r_start   = rd_total;
        req_vaddr = va; req_write = w; req_user = u; req_fetch = f; nx_en = nx;
        root_base = ROOT; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
    endtask

    localparam logic [63:0] VA_LO = 64'h0000_7123_4567_89AB;
    localparam logic [63:0] VA_HI = 64'hFFFF_8000_1234_5678;
    localparam logic [63:0] VA_BAD = 64'h0001_0000_0000_0000;

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 mem_req", mem_req, 0);
    endtask

    task automatic t_basic();
        build(VA_LO, 4'h7, 4'h7, 4'h7, 4'h7);
        run(VA_LO, 0, 0, 0, 0);
        chk("R4 fault", r_fault, 0);
        chk("R4 level", r_level, 3);
        chk("R4 paddr", r_paddr, {FRAME[39:12], VA_LO[11:0]});
        chk("R3 reads", r_reads, 4);
        chk("R3 addr0", rd_log[(r_start + 0) % 8], eaddr(ROOT, VA_LO[47:39]));
        chk("R3 addr1", rd_log[(r_start + 1) % 8], eaddr(TB1, VA_LO[38:30]));
        chk("R3 addr2", rd_log[(r_start + 2) % 8], eaddr(TB2, VA_LO[29:21]));
        chk("R3 addr3", rd_log[(r_start + 3) % 8], eaddr(TB3, VA_LO[20:12]));
    endtask

    task automatic t_high();
        build(VA_HI, 4'h7, 4'h7, 4'h7, 4'h7);
        run(VA_HI, 1, 1, 0, 1);
        chk("R4 high fault", r_fault, 0);
        chk("R4 high paddr", r_paddr, {FRAME[39:12], VA_HI[11:0]});
    endtask

    task automatic t_noncanon();
        build(VA_BAD, 4'h7, 4'h7, 4'h7, 4'h7);
        run(VA_BAD, 0, 0, 0, 0);
        chk("R2 fault", r_fault, 1);
        chk("R2 level", r_level, 0);
        chk("R2 reads", r_reads, 0);
        run(64'hFFFF_0000_0000_0000, 0, 0, 0, 0);
        chk("R2 high-nonsign fault", r_fault, 1);
    endtask

    task automatic t_notpres();
        build(VA_LO, 4'h7, 4'h7, 4'h6, 4'h7);
        run(VA_LO, 0, 0, 0, 0);
        chk("R5 fault", r_fault, 2);
        chk("R5 level", r_level, 2);
        chk("R5 reads", r_reads, 3);
    endtask

    task automatic t_write();
        build(VA_LO, 4'h7, 4'h5, 4'h7, 4'h7);
        run(VA_LO, 1, 0, 0, 0);
        chk("R6 fault", r_fault, 3);
        chk("R6 level", r_level, 1);
        run(VA_LO, 0, 0, 0, 0);
        chk("R6 read ok", r_fault, 0);
    endtask

    task automatic t_user();
        build(VA_LO, 4'h7, 4'h7, 4'h7, 4'h3);
        run(VA_LO, 0, 1, 0, 0);
        chk("R7 fault", r_fault, 4);
        chk("R7 level", r_level, 3);
        run(VA_LO, 0, 0, 0, 0);
        chk("R7 supervisor ok", r_fault, 0);
    endtask

    task automatic t_nx();
        build(VA_LO, 4'hF, 4'h7, 4'h7, 4'h7);
        run(VA_LO, 0, 0, 1, 1);
        chk("R8 fault", r_fault, 5);
        chk("R8 level", r_level, 0);
        run(VA_LO, 0, 0, 1, 0);
        chk("R8 disabled ok", r_fault, 0);
        chk("R8 disabled paddr", r_paddr, {FRAME[39:12], VA_LO[11:0]});
        run(VA_LO, 0, 0, 0, 1);
        chk("R8 data ok", r_fault, 0);
    endtask

    task automatic t_prio();
        build(VA_LO, 4'h7, 4'h8, 4'h7, 4'h7);
        run(VA_LO, 1, 1, 1, 1);
        chk("R9 notpres first", r_fault, 2);
        build(VA_LO, 4'h7, 4'h9, 4'h7, 4'h7);
        run(VA_LO, 1, 1, 1, 1);
        chk("R9 write before user", r_fault, 3);
        build(VA_LO, 4'h7, 4'hB, 4'h7, 4'h7);
        run(VA_LO, 1, 1, 1, 1);
        chk("R9 user before nx", r_fault, 4);
    endtask

    task automatic t_busy();
        int extra = 0;
        build(VA_LO, 4'h7, 4'h7, 4'h7, 4'h7);
        @(negedge clk);
        r_start   = rd_total;
        req_vaddr = VA_LO; req_write = 0; req_user = 0; req_fetch = 0; nx_en = 0;
        root_base = ROOT; req_valid = 1'b1;
        @(negedge clk);
        chk("R10 busy after accept", busy, 1);
        req_vaddr = VA_BAD;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        chk("R10 first result kept", r_fault, 0);
        chk("R10 first paddr", r_paddr, {FRAME[39:12], VA_LO[11:0]});
        chk("R10 busy after done", busy, 0);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R10 dropped request", extra, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_high();
        t_noncanon();
        t_notpres();
        t_write();
        t_user();
        t_nx();
        t_prio();
        t_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule